// File: doc/BRIEF.md
# Character Display Instruction Controller

This block carries out host commands for a character display that has two lines of 40 columns. It takes register-select, write and read strobes from an external bus adapter, which is not part of this block. It decodes the command byte and keeps the shared 7-bit cursor address, which can point at either the display memory or the glyph memory. It also holds the entry-direction and auto-shift flags, the display, cursor and blink switches, the bus-width, line-count and brightness settings, and the horizontal scroll offset.

All RAM traffic leaves through a single memory port. Writes to that port take effect in the same cycle. Reads are synchronous and return data one cycle after they are issued. Host reads never touch the memory directly. They return a holding register that the block fills ahead of time, and it refills that register whenever the cursor is repositioned or a data read is accepted.

Any accepted command raises the busy flag for a fixed number of cycles. The erase command raises it for longer while a sweep writes the blank code into every visible location. Reset performs the same erase and then loads the default settings.

Top module: `chardisp_ctrl`

## Requirements
- R1: After reset the block is busy while it erases the display memory. Afterwards the status word is 00h. Display, cursor and blink are off, the bus is 8-bit, two lines are selected, the brightness code is 0, the scroll offset is 0, the direction is increment and auto-shift is off.
- R2: Command 01h holds busy for 2*COLS+OP_CYCLES cycles. It writes 20h to addresses 00h..COLS-1 and 40h..40h+COLS-1 and to no other address. It zeroes the cursor address, selects display memory, zeroes the scroll offset and restores increment direction.
- R3: Commands 02h/03h zero the cursor address, select display memory and zero the scroll offset, and change no memory location.
- R4: Commands 04h..07h set the direction from bit 1 (1 = increment) and auto-shift from bit 0. Every accepted data write or data read moves the cursor address one step in that direction.
- R5: Display-memory stepping goes from COLS-1 to 40h and from 40h+COLS-1 to 00h when incrementing, and the reverse when decrementing.
- R6: Commands 40h..7Fh select glyph memory and load bits 5:0 as the address. In glyph memory the address steps modulo 64 with bit 6 held at 0.
- R7: With auto-shift on, a display-memory write also changes the scroll offset modulo COLS: +1 when incrementing, -1 when decrementing.
- R8: Commands 10h..1Fh move the cursor one step, to the right when bit 2 = 1. When bit 3 = 1 the scroll offset also changes: -1 for right and +1 for left.
- R9: Command 08h..0Fh sets display/cursor/blink from bits 2/1/0. Command 20h..3Fh sets the 8-bit bus from bit 4, two lines from bit 3 and brightness from bits 1:0.
- R10: Every other accepted command, data write or data read holds busy for OP_CYCLES cycles. A write or data read issued while busy is ignored.
- R11: With rs=0, rd_data is the status word: busy in bit 7 and the cursor address in bits 6:0. It can be read at any time.
- R12: With rs=1, rd_data is the holding register. An address-set command, a shift command or an accepted data read refills it from the new cursor address. A data write does not refill it, so a read that follows a write returns stale data.
- R13: Command 80h..FFh selects display memory and loads bits 6:0 as the cursor address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts the erase sweep |
| rs | input | 1 | 0 = command/status, 1 = data |
| wr_req | input | 1 | Host write strobe, one cycle |
| rd_req | input | 1 | Host read strobe, one cycle |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Status word or holding register |
| ram_we | output | 1 | Memory write enable |
| ram_re | output | 1 | Memory read enable, data due next cycle |
| ram_cg | output | 1 | 1 = glyph memory, 0 = display memory |
| ram_addr | output | 7 | Memory address |
| ram_wdata | output | 8 | Memory write data |
| ram_rdata | input | 8 | Memory read data |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| bus_8bit | output | 1 | Bus width setting |
| two_line | output | 1 | Line count setting |
| bright | output | 2 | Brightness code |
| shift_ofs | output | 6 | Scroll offset, 0..COLS-1 |

## Verification
The stale read is the hardest case to reach. It needs a cursor set, then a data write, then a data read with no repositioning in between. The bench builds exactly that sequence and then repositions the cursor to show that the refilled value is correct. The wrap of the scroll offset below zero is also hard to reach. It only appears after decrementing auto-shift writes, which the bench drives from offset 1 down past 0. The ignore-while-busy rule is tested by holding the write strobe for a second cycle, which puts the second command into the first one's busy window.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  localparam int LINE2 = 64;

  typedef enum logic [3:0] {
    OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
    OP_SHIFT, OP_FUNC, OP_SETCG, OP_SETDD
  } op_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FILL, SQ_WAIT} seq_e;

  // one step of the display-memory address across the two line windows
  function automatic logic [6:0] dd_step(input logic [6:0] a, input logic inc, input int cols);
    logic [6:0] e1, b2, e2;
    e1 = 7'(cols - 1);
    b2 = 7'(LINE2);
    e2 = 7'(LINE2 + cols - 1);
    if (inc) begin
      if (a == e1) return b2;
      if (a == e2) return 7'd0;
      return a + 7'd1;
    end
    if (a == 7'd0) return e2;
    if (a == b2) return e1;
    return a - 7'd1;
  endfunction

  function automatic logic [6:0] cg_step(input logic [6:0] a, input logic inc);
    logic [5:0] low;
    low = inc ? a[5:0] + 6'd1 : a[5:0] - 6'd1;
    return {1'b0, low};
  endfunction

  function automatic int ofs_step(input int ofs, input logic left, input int cols);
    if (left) return (ofs == cols - 1) ? 0 : ofs + 1;
    return (ofs == 0) ? cols - 1 : ofs - 1;
  endfunction

  function automatic logic [6:0] fill_addr(input int idx, input int cols);
    return (idx < cols) ? 7'(idx) : 7'(idx - cols + LINE2);
  endfunction

  function automatic logic dd_valid(input logic [6:0] a, input int cols);
    return (int'(a) < cols) || (int'(a) >= LINE2 && int'(a) < LINE2 + cols);
  endfunction

endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
  import chardisp_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    if (code[7])      op = OP_SETDD;
    else if (code[6]) op = OP_SETCG;
    else if (code[5]) op = OP_FUNC;
    else if (code[4]) op = OP_SHIFT;
    else if (code[3]) op = OP_DISP;
    else if (code[2]) op = OP_ENTRY;
    else if (code[1]) op = OP_HOME;
    else if (code[0]) op = OP_CLEAR;
    else              op = OP_NOP;
  end
endmodule

// File: rtl/chardisp_seq.sv
module chardisp_seq
  import chardisp_pkg::*;
#(
  parameter int FILL      = 80,
  parameter int OP_CYCLES = 4,
  localparam int CW       = $clog2(FILL + OP_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_op,
  input  logic          start_clear,
  input  logic          start_pf,
  output logic          busy,
  output logic          clr_active,
  output logic [CW-1:0] clr_idx,
  output logic          pf_issue,
  output logic          pf_capture
);
  seq_e          state;
  logic [CW-1:0] cnt;
  logic          pf1, pf2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_FILL;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start_clear) begin
            state <= SQ_FILL;
            cnt   <= '0;
          end else if (start_op) begin
            state <= SQ_WAIT;
            cnt   <= CW'(OP_CYCLES - 1);
          end
        end
        SQ_FILL: begin
          if (cnt == CW'(FILL - 1)) begin
            state <= SQ_WAIT;
            cnt   <= CW'(OP_CYCLES - 1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_WAIT: begin
          if (cnt == '0) state <= SQ_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf1 <= 1'b0;
      pf2 <= 1'b0;
    end else begin
      pf1 <= start_pf;
      pf2 <= pf1;
    end
  end

  assign busy       = (state != SQ_IDLE);
  assign clr_active = (state == SQ_FILL);
  assign clr_idx    = cnt;
  assign pf_issue   = pf1;
  assign pf_capture = pf2;
endmodule

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
  import chardisp_pkg::*;
#(
  parameter int COLS      = 40,
  parameter int OP_CYCLES = 4,
  localparam int FILL     = 2 * COLS,
  localparam int SW       = $clog2(COLS),
  localparam int CW       = $clog2(FILL + OP_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rs,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          ram_we,
  output logic          ram_re,
  output logic          ram_cg,
  output logic [6:0]    ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata,
  output logic          disp_on,
  output logic          cursor_on,
  output logic          blink_on,
  output logic          bus_8bit,
  output logic          two_line,
  output logic [1:0]    bright,
  output logic [SW-1:0] shift_ofs
);
  // named internal events
  logic          busy, clr_active, pf_issue, pf_capture;
  logic [CW-1:0] clr_idx;
  logic          cmd_acc, dwr_acc, drd_acc;
  logic          start_op, start_clear, start_pf;
  op_e           op;

  logic [6:0] ac_q;
  logic       sel_cg_q, inc_q, autoshift_q;
  logic [7:0] hold_q;

  assign cmd_acc = wr_req && !rs && !busy;
  assign dwr_acc = wr_req &&  rs && !busy;
  assign drd_acc = rd_req &&  rs && !busy;

  chardisp_decode u_dec (.code(wr_data), .op(op));

  assign start_clear = cmd_acc && (op == OP_CLEAR);
  assign start_op    = (cmd_acc && (op != OP_CLEAR)) || dwr_acc || drd_acc;
  assign start_pf    = drd_acc ||
                       (cmd_acc && (op == OP_SETCG || op == OP_SETDD || op == OP_SHIFT));

  chardisp_seq #(.FILL(FILL), .OP_CYCLES(OP_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_op(start_op), .start_clear(start_clear), .start_pf(start_pf),
    .busy(busy), .clr_active(clr_active), .clr_idx(clr_idx),
    .pf_issue(pf_issue), .pf_capture(pf_capture)
  );

  function automatic logic [6:0] ac_step(input logic [6:0] a, input logic cg, input logic inc);
    return cg ? cg_step(a, inc) : dd_step(a, inc, COLS);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q        <= '0;
      sel_cg_q    <= 1'b0;
      inc_q       <= 1'b1;
      autoshift_q <= 1'b0;
      disp_on     <= 1'b0;
      cursor_on   <= 1'b0;
      blink_on    <= 1'b0;
      bus_8bit    <= 1'b1;
      two_line    <= 1'b1;
      bright      <= 2'd0;
      shift_ofs   <= '0;
    end else if (cmd_acc) begin
      case (op)
        OP_CLEAR: begin
          ac_q      <= '0;
          sel_cg_q  <= 1'b0;
          inc_q     <= 1'b1;
          shift_ofs <= '0;
        end
        OP_HOME: begin
          ac_q      <= '0;
          sel_cg_q  <= 1'b0;
          shift_ofs <= '0;
        end
        OP_ENTRY: begin
          inc_q       <= wr_data[1];
          autoshift_q <= wr_data[0];
        end
        OP_DISP: begin
          disp_on   <= wr_data[2];
          cursor_on <= wr_data[1];
          blink_on  <= wr_data[0];
        end
        OP_SHIFT: begin
          ac_q <= ac_step(ac_q, sel_cg_q, wr_data[2]);
          if (wr_data[3])
            shift_ofs <= SW'(ofs_step(int'(shift_ofs), !wr_data[2], COLS));
        end
        OP_FUNC: begin
          bus_8bit <= wr_data[4];
          two_line <= wr_data[3];
          bright   <= wr_data[1:0];
        end
        OP_SETCG: begin
          ac_q     <= {1'b0, wr_data[5:0]};
          sel_cg_q <= 1'b1;
        end
        OP_SETDD: begin
          ac_q     <= wr_data[6:0];
          sel_cg_q <= 1'b0;
        end
        default: ;
      endcase
    end else if (dwr_acc) begin
      ac_q <= ac_step(ac_q, sel_cg_q, inc_q);
      if (autoshift_q && !sel_cg_q)
        shift_ofs <= SW'(ofs_step(int'(shift_ofs), inc_q, COLS));
    end else if (drd_acc) begin
      ac_q <= ac_step(ac_q, sel_cg_q, inc_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= '0;
    else if (pf_capture) hold_q <= ram_rdata;
  end

  assign ram_we    = clr_active || dwr_acc;
  assign ram_re    = pf_issue;
  assign ram_cg    = clr_active ? 1'b0 : sel_cg_q;
  assign ram_addr  = clr_active ? fill_addr(int'(clr_idx), COLS) : ac_q;
  assign ram_wdata = clr_active ? 8'h20 : wr_data;
  assign rd_data   = rs ? hold_q : {busy, ac_q};
endmodule

// File: rtl/chardisp_ctrl_sva.sv
module chardisp_ctrl_sva
  import chardisp_pkg::*;
#(
  parameter int COLS = 40,
  parameter int SW   = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_req,
  input logic          rd_req,
  input logic          busy,
  input logic          clr_active,
  input logic          pf_issue,
  input logic          dwr_acc,
  input logic          drd_acc,
  input logic          ram_we,
  input logic          ram_cg,
  input logic [7:0]    ram_wdata,
  input logic [6:0]    ac_q,
  input logic          sel_cg_q,
  input logic [SW-1:0] shift_ofs
);
  // R10: a write seen while busy leaves the cursor unchanged
  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_req) |=> $stable(ac_q));

  // R10: a host-driven memory write happens only when idle
  p_write_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !clr_active) |-> !busy);

  // R2: the sweep writes blanks into display memory under busy
  p_sweep_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |-> (busy && ram_we && !ram_cg && ram_wdata == 8'h20));

  // R6: glyph addressing keeps bit 6 clear
  p_cg_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cg_q |-> !ac_q[6]);

  // R5: stepping from a visible display address stays visible
  p_dd_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dwr_acc || drd_acc) && !sel_cg_q && dd_valid(ac_q, COLS)) |=> dd_valid(ac_q, COLS));

  // R7: scroll offset stays below the column count
  p_ofs_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(shift_ofs) < COLS);

  // R12: refill reads are issued inside the busy window
  p_refill_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pf_issue |-> busy);
endmodule

bind chardisp_ctrl chardisp_ctrl_sva #(.COLS(COLS), .SW(SW)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
  .busy(busy), .clr_active(clr_active), .pf_issue(pf_issue),
  .dwr_acc(dwr_acc), .drd_acc(drd_acc), .ram_we(ram_we), .ram_cg(ram_cg),
  .ram_wdata(ram_wdata), .ac_q(ac_q), .sel_cg_q(sel_cg_q), .shift_ofs(shift_ofs)
);

// File: tb/chardisp_ctrl_tb_top.sv
module chardisp_ctrl_tb_top;
  localparam int COLS = 40;
  localparam int OPC  = 4;
  localparam int SW   = $clog2(COLS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic rs = 1'b0, wr_req = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic ram_we, ram_re, ram_cg;
  logic [6:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata;
  logic disp_on, cursor_on, blink_on, bus_8bit, two_line;
  logic [1:0] bright;
  logic [SW-1:0] shift_ofs;

  always #5 clk = ~clk;

  chardisp_ctrl #(.COLS(COLS), .OP_CYCLES(OPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .rs(rs), .wr_req(wr_req), .rd_req(rd_req),
    .wr_data(wr_data), .rd_data(rd_data), .ram_we(ram_we), .ram_re(ram_re),
    .ram_cg(ram_cg), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .disp_on(disp_on), .cursor_on(cursor_on),
    .blink_on(blink_on), .bus_8bit(bus_8bit), .two_line(two_line),
    .bright(bright), .shift_ofs(shift_ofs)
  );

  // external memory model
  logic [7:0] mem_dd [128];
  logic [7:0] mem_cg [64];
  logic [7:0] rdq = '0;
  assign ram_rdata = rdq;
  always @(posedge clk) begin
    if (ram_we) begin
      if (ram_cg) mem_cg[ram_addr[5:0]] = ram_wdata;
      else        mem_dd[ram_addr]      = ram_wdata;
    end
    if (ram_re) rdq <= ram_cg ? mem_cg[ram_addr[5:0]] : mem_dd[ram_addr];
  end

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      logic [7:0] e, a;
      string t;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      t = tag_q.pop_front();
      check(t, a, e);
    end
  end

  task automatic wait_idle();
    rs = 1'b0;
    #1;
    while (rd_data[7]) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(logic r, logic [7:0] d);
    @(negedge clk);
    rs = r; wr_data = d; wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    wait_idle();
  endtask

  task automatic rd_expect(logic [7:0] e, string tag);
    @(negedge clk);
    rs = 1'b1; rd_req = 1'b1;
    #1;
    exp_q.push_back(e); tag_q.push_back(tag); act_q.push_back(rd_data);
    @(negedge clk);
    rd_req = 1'b0;
    wait_idle();
  endtask

  task automatic status_expect(logic [7:0] e, string tag);
    @(negedge clk);
    rs = 1'b0;
    #1;
    exp_q.push_back(e); tag_q.push_back(tag); act_q.push_back(rd_data);
  endtask

  // issue a command and count busy cycles
  task automatic busy_len(logic [7:0] d, output int n);
    @(negedge clk);
    rs = 1'b0; wr_data = d; wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    n = 0;
    #1;
    while (rd_data[7]) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard leftover", exp_q.size(), 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    check("watchdog", 1, 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, bad;
    for (int i = 0; i < 128; i++) mem_dd[i] = 8'hFF;
    for (int i = 0; i < 64; i++)  mem_cg[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 busy after reset", rd_data[7], 1);
    wait_idle();
    status_expect(8'h00, "R1 R11 status after reset");
    check("R1 disp_on", disp_on, 0);
    check("R1 cursor_on", cursor_on, 0);
    check("R1 blink_on", blink_on, 0);
    check("R1 bus_8bit", bus_8bit, 1);
    check("R1 two_line", two_line, 1);
    check("R1 bright", bright, 0);
    check("R1 shift_ofs", shift_ofs, 0);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      logic vis;
      vis = (i < COLS) || (i >= 64 && i < 64 + COLS);
      if (mem_dd[i] != (vis ? 8'h20 : 8'hFF)) bad++;
    end
    check("R1 R2 sweep contents", bad, 0);

    // R4 increment stepping, R5 wraps
    wr(1'b1, 8'h41);
    check("R4 write lands", mem_dd[0], 8'h41);
    status_expect(8'h01, "R4 step after write");
    wr(1'b0, 8'hA7);
    status_expect(8'h27, "R13 set display addr");
    wr(1'b1, 8'h42);
    status_expect(8'h40, "R5 wrap 27h->40h");
    wr(1'b1, 8'h43);
    check("R5 write at 40h", mem_dd[8'h40], 8'h43);
    wr(1'b0, 8'hE7);
    wr(1'b1, 8'h44);
    status_expect(8'h00, "R5 wrap 67h->00h");

    // decrement
    wr(1'b0, 8'h04);
    wr(1'b0, 8'hC0);
    wr(1'b1, 8'h45);
    status_expect(8'h27, "R4 R5 dec 40h->27h");
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h46);
    status_expect(8'h67, "R5 dec 00h->67h");
    wr(1'b0, 8'h06);

    // R12 stale read and refill
    wr(1'b0, 8'h85);
    wr(1'b1, 8'h55);
    rd_expect(8'h20, "R12 stale read after write");
    status_expect(8'h07, "R12 read steps cursor");
    wr(1'b0, 8'h85);
    rd_expect(8'h55, "R12 refill on address set");
    rd_expect(8'h20, "R12 refill after read");

    // R6 glyph memory
    wr(1'b0, 8'h7F);
    status_expect(8'h3F, "R6 set glyph addr");
    wr(1'b1, 8'h1F);
    check("R6 glyph write", mem_cg[63], 8'h1F);
    status_expect(8'h00, "R6 glyph wrap 3Fh->00h");
    wr(1'b0, 8'h7F);
    rd_expect(8'h1F, "R6 R12 glyph read");

    // R10 ignore while busy
    @(negedge clk);
    rs = 1'b0; wr_data = 8'h90; wr_req = 1'b1;
    @(negedge clk);
    wr_data = 8'hA0;
    @(negedge clk);
    wr_req = 1'b0;
    wait_idle();
    status_expect(8'h10, "R10 second command ignored");
    busy_len(8'h0E, n);
    check("R10 busy length", n, OPC);
    check("R9 disp_on", disp_on, 1);
    check("R9 cursor_on", cursor_on, 1);
    check("R9 blink_on", blink_on, 0);
    wr(1'b0, 8'h27);
    check("R9 bus_8bit", bus_8bit, 0);
    check("R9 two_line", two_line, 0);
    check("R9 bright", bright, 3);

    // R7 auto-shift, R8 shift command
    wr(1'b0, 8'h07);
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h61);
    check("R7 shift on inc write", shift_ofs, 1);
    wr(1'b0, 8'h18);
    check("R8 display left", shift_ofs, 2);
    status_expect(8'h00, "R8 cursor left");
    wr(1'b0, 8'h1C);
    check("R8 display right", shift_ofs, 1);
    wr(1'b0, 8'h14);
    check("R8 cursor only keeps offset", shift_ofs, 1);
    status_expect(8'h02, "R8 cursor right");
    wr(1'b0, 8'h05);
    wr(1'b1, 8'h62);
    check("R7 shift on dec write", shift_ofs, 0);
    wr(1'b1, 8'h63);
    check("R7 offset wrap below zero", shift_ofs, COLS - 1);

    // R3 home
    wr(1'b0, 8'h02);
    check("R3 offset zero", shift_ofs, 0);
    status_expect(8'h00, "R3 cursor zero");
    check("R3 memory kept", mem_dd[2], 8'h62);

    // R2 erase command
    busy_len(8'h01, n);
    check("R2 busy length", n, 2 * COLS + OPC);
    check("R2 blanked", mem_dd[2], 8'h20);
    check("R2 offset zero", shift_ofs, 0);
    check("R2 outside kept", mem_dd[8'h30], 8'hFF);
    wr(1'b1, 8'h70);
    status_expect(8'h01, "R2 increment restored");

    finish_run();
  end
endmodule